// File: doc/BRIEF.md
# Identifier-Tagged Page Translation Unit

This block turns a 32-bit virtual address into a physical address within one combinational cycle. It looks at the top three address bits to decide how the address is handled. The control region passes through unchanged. The two directly mapped kernel regions get a fixed translation: the top three bits are cleared and no table entry is read. The user region and the mapped kernel region go to a small fully associative table. Every entry of the table is compared at the same time.

Each table entry holds a valid flag, a virtual page number, an 8-bit process identifier and a physical page number, with 4 KB pages. Software loads entries one at a time through a synchronous write port. A mode input selects how identifiers take part in a lookup. In shared-space mode an entry matches only when its stored identifier equals the current identifier, so entries of several processes can stay resident together. In exclusive-space mode page numbers are unique, and the identifier serves only as protection for unprivileged accesses. The write port refuses any load that would leave two valid entries with the same page number and different identifiers in this mode.

Each cycle the unit reports exactly one outcome: a good translation, a miss, a protection violation or a multiple match. The miss outcome lets the surrounding logic refill the table and retry the access.

Top module: `asid_tlb_xlate`

## Requirements
- R1: After reset every table entry is invalid, so any address in a mapped region reports a miss.
- R2: An address with bits [31:29] = 3'b111 (control region) gives ok with the physical address equal to the virtual address.
- R3: An address with bits [31:29] = 3'b100 or 3'b101 gives ok with the physical address equal to the virtual address with bits [31:29] cleared, whatever the table holds.
- R4: An address with bit 31 = 0 or bits [31:29] = 3'b110 that matches exactly one entry gives ok with the physical address {zeros, stored page, va[11:0]}.
- R5: A mapped-region address that matches no entry gives miss, and the physical address output is zero.
- R6: When shared_mode_i = 1, an entry whose stored identifier differs from asid_i does not match, and the access gives miss if no other entry matches.
- R7: When shared_mode_i = 0 and priv_i = 1, the identifier is ignored, and a page-number match gives ok.
- R8: When shared_mode_i = 0 and priv_i = 0, a page-number match with a different stored identifier gives prot_o with a zero physical address.
- R9: When shared_mode_i = 0, a valid load whose page number equals that of another valid entry (not at wr_idx_i) with a different identifier raises wr_rej_o in the same cycle and leaves the table unchanged. No load is refused in shared mode.
- R10: When more than one entry matches, multi_o is raised, ok_o is low and the physical address output is zero.
- R11: In every cycle exactly one of ok_o, miss_o, prot_o and multi_o is high.
- R12: A load that is not refused overwrites the entry at wr_idx_i on the clock edge, and a load with wr_valid_i = 0 removes that entry from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table loads |
| rst_n | input | 1 | Active-low asynchronous reset, clears all valid flags |
| va_i | input | 32 | Virtual address to translate |
| asid_i | input | 8 | Identifier of the running process |
| shared_mode_i | input | 1 | 1 = shared-space tag compare, 0 = exclusive-space |
| priv_i | input | 1 | 1 = privileged access |
| pa_o | output | 32 | Physical address, zero unless ok_o |
| ok_o | output | 1 | Translation is good |
| miss_o | output | 1 | No entry matched a mapped-region address |
| prot_o | output | 1 | Identifier protection violation |
| multi_o | output | 1 | More than one entry matched |
| wr_en_i | input | 1 | Load strobe for the table |
| wr_idx_i | input | 3 | Entry index to load |
| wr_valid_i | input | 1 | Valid flag to store |
| wr_vpn_i | input | 20 | Virtual page number to store |
| wr_asid_i | input | 8 | Identifier to store |
| wr_ppn_i | input | 17 | Physical page number to store |
| wr_rej_o | output | 1 | Load refused because of an identifier clash |

## Verification
The assertions assume that every input holds a known value from reset release onward. They also assume that inputs change only between clock edges, so the combinational outcome can be sampled at any point in the cycle. The bench drives all inputs from time zero and changes them only on the falling edge. It checks the combinational results a short time later, and it checks the write port before the rising edge that would commit the load. The clash check assumes that the mode bit is not changed while clashing entries sit in the table. The stimulus creates duplicate page numbers only on purpose: for the multiple-match case, and when it tests a refused load.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

   typedef enum logic [2:0] {
      RG_USER,
      RG_KDIR_C,
      RG_KDIR_U,
      RG_KMAP,
      RG_CTRL
   } region_e;

   function automatic region_e region_of(input logic [2:0] top);
      region_e r;
      if (!top[2])             r = RG_USER;
      else if (top == 3'b100)  r = RG_KDIR_C;
      else if (top == 3'b101)  r = RG_KDIR_U;
      else if (top == 3'b110)  r = RG_KMAP;
      else                     r = RG_CTRL;
      return r;
   endfunction

endpackage

// File: rtl/tlbx_region_dec.sv
module tlbx_region_dec
   import tlbx_pkg::*;
(
   input  logic [2:0] va_top,
   output logic       lookup,
   output logic       direct,
   output logic       bypass
);
   region_e rg;

   always_comb begin
      rg     = region_of(va_top);
      lookup = (rg == RG_USER) || (rg == RG_KMAP);
      direct = (rg == RG_KDIR_C) || (rg == RG_KDIR_U);
      bypass = (rg == RG_CTRL);
   end
endmodule

// File: rtl/tlbx_entry.sv
module tlbx_entry #(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int PPN_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              ld_valid,
   input  logic [VPN_W-1:0]  ld_vpn,
   input  logic [ASID_W-1:0] ld_asid,
   input  logic [PPN_W-1:0]  ld_ppn,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   output logic              page_eq,
   output logic              id_eq,
   output logic              clash,
   output logic [PPN_W-1:0]  ppn
);
   logic              vld_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic [PPN_W-1:0]  ppn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         vpn_q  <= '0;
         asid_q <= '0;
         ppn_q  <= '0;
      end else if (ld) begin
         vld_q  <= ld_valid;
         vpn_q  <= ld_vpn;
         asid_q <= ld_asid;
         ppn_q  <= ld_ppn;
      end
   end

   assign page_eq = vld_q && (vpn_q == q_vpn);
   assign id_eq   = (asid_q == q_asid);
   assign clash   = vld_q && (vpn_q == ld_vpn) && (asid_q != ld_asid);
   assign ppn     = ppn_q;
endmodule

// File: rtl/tlbx_select.sv
module tlbx_select #(
   parameter int N_ENT = 8,
   parameter int PPN_W = 17
) (
   input  logic [N_ENT-1:0]            hit_vec,
   input  logic [N_ENT-1:0]            idm_vec,
   input  logic [N_ENT-1:0][PPN_W-1:0] ppn_vec,
   output logic                        any_hit,
   output logic                        many_hit,
   output logic                        id_bad,
   output logic [PPN_W-1:0]            ppn_sel
);
   localparam int CNT_W = $clog2(N_ENT + 1);
   logic [CNT_W-1:0] cnt;

   always_comb begin
      cnt     = '0;
      ppn_sel = '0;
      id_bad  = 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
         cnt     = cnt + CNT_W'(hit_vec[i]);
         ppn_sel = ppn_sel | (ppn_vec[i] & {PPN_W{hit_vec[i]}});
         id_bad  = id_bad | (hit_vec[i] & idm_vec[i]);
      end
      any_hit  = (cnt != '0);
      many_hit = (cnt > CNT_W'(1));
   end
endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate #(
   parameter int N_ENT     = 8,
   parameter int ASID_W    = 8,
   parameter int PAGE_BITS = 12,
   parameter int PPN_W     = 17,
   localparam int VPN_W    = 32 - PAGE_BITS,
   localparam int IDX_W    = $clog2(N_ENT),
   localparam int PAD_W    = 32 - PPN_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       va_i,
   input  logic [ASID_W-1:0] asid_i,
   input  logic              shared_mode_i,
   input  logic              priv_i,
   output logic [31:0]       pa_o,
   output logic              ok_o,
   output logic              miss_o,
   output logic              prot_o,
   output logic              multi_o,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic              wr_valid_i,
   input  logic [VPN_W-1:0]  wr_vpn_i,
   input  logic [ASID_W-1:0] wr_asid_i,
   input  logic [PPN_W-1:0]  wr_ppn_i,
   output logic              wr_rej_o
);
   generate
      if (N_ENT < 2)
         $error("N_ENT must be at least 2");
      if (PAGE_BITS < 10 || PAGE_BITS > 20)
         $error("PAGE_BITS out of range");
      if (PAD_W < 3)
         $error("physical page plus offset must fit in 29 bits");
   endgenerate

   logic lookup, direct, bypass;

   tlbx_region_dec i_rdec (
      .va_top (va_i[31:29]),
      .lookup (lookup),
      .direct (direct),
      .bypass (bypass)
   );

   logic [N_ENT-1:0]            page_eq, id_eq, clash, clash_oth, ld, hit_vec, idm_vec;
   logic [N_ENT-1:0][PPN_W-1:0] ppn_vec;

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      tlbx_entry #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) i_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld       (ld[g]),
         .ld_valid (wr_valid_i),
         .ld_vpn   (wr_vpn_i),
         .ld_asid  (wr_asid_i),
         .ld_ppn   (wr_ppn_i),
         .q_vpn    (va_i[31:PAGE_BITS]),
         .q_asid   (asid_i),
         .page_eq  (page_eq[g]),
         .id_eq    (id_eq[g]),
         .clash    (clash[g]),
         .ppn      (ppn_vec[g])
      );
      assign clash_oth[g] = clash[g] && (wr_idx_i != IDX_W'(g));
      assign ld[g]        = wr_en_i && (wr_idx_i == IDX_W'(g)) && !wr_rej_o;
      assign hit_vec[g]   = page_eq[g] && (id_eq[g] || !shared_mode_i);
      assign idm_vec[g]   = !id_eq[g];
   end

   assign wr_rej_o = wr_en_i && wr_valid_i && !shared_mode_i && (|clash_oth);

   logic             any_hit, many_hit, id_bad;
   logic [PPN_W-1:0] ppn_sel;

   tlbx_select #(.N_ENT(N_ENT), .PPN_W(PPN_W)) i_sel (
      .hit_vec  (hit_vec),
      .idm_vec  (idm_vec),
      .ppn_vec  (ppn_vec),
      .any_hit  (any_hit),
      .many_hit (many_hit),
      .id_bad   (id_bad),
      .ppn_sel  (ppn_sel)
   );

   always_comb begin
      pa_o    = '0;
      ok_o    = 1'b0;
      miss_o  = 1'b0;
      prot_o  = 1'b0;
      multi_o = 1'b0;
      if (bypass) begin
         ok_o = 1'b1;
         pa_o = va_i;
      end else if (direct) begin
         ok_o = 1'b1;
         pa_o = {3'b000, va_i[28:0]};
      end else if (lookup) begin
         if (!any_hit)
            miss_o = 1'b1;
         else if (many_hit)
            multi_o = 1'b1;
         else if (!shared_mode_i && !priv_i && id_bad)
            prot_o = 1'b1;
         else begin
            ok_o = 1'b1;
            pa_o = {{PAD_W{1'b0}}, ppn_sel, va_i[PAGE_BITS-1:0]};
         end
      end
   end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] va_i,
   input logic        shared_mode_i,
   input logic        priv_i,
   input logic [31:0] pa_o,
   input logic        ok_o,
   input logic        miss_o,
   input logic        prot_o,
   input logic        multi_o,
   input logic        wr_en_i,
   input logic        wr_valid_i,
   input logic        wr_rej_o
);
   a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ok_o, miss_o, prot_o, multi_o}) == 1);

   a_r2_ctrl_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (va_i[31:29] == 3'b111) |-> (ok_o && pa_o == va_i));

   a_r3_direct_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (va_i[31:30] == 2'b10) |-> (ok_o && pa_o[31:29] == 3'b000 && pa_o[28:0] == va_i[28:0]));

   a_r5_miss_mapped_only: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> ((!va_i[31] || va_i[31:29] == 3'b110) && pa_o == 32'h0));

   a_r8_prot_user_excl: assert property (@(posedge clk) disable iff (!rst_n)
      prot_o |-> (!shared_mode_i && !priv_i && pa_o == 32'h0));

   a_r10_multi_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      multi_o |-> (!ok_o && pa_o == 32'h0));

   a_r9_rej_excl_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rej_o |-> (wr_en_i && wr_valid_i && !shared_mode_i));
endmodule

bind asid_tlb_xlate tlbx_chk i_tlbx_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .va_i          (va_i),
   .shared_mode_i (shared_mode_i),
   .priv_i        (priv_i),
   .pa_o          (pa_o),
   .ok_o          (ok_o),
   .miss_o        (miss_o),
   .prot_o        (prot_o),
   .multi_o       (multi_o),
   .wr_en_i       (wr_en_i),
   .wr_valid_i    (wr_valid_i),
   .wr_rej_o      (wr_rej_o)
);

// File: tb/test_asid_tlb_xlate.sv
`timescale 1ns/1ps
module test_asid_tlb_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] va = '0;
   logic [7:0]  asid = '0;
   logic        shmode = 1'b1;
   logic        priv = 1'b0;
   logic [31:0] pa;
   logic        ok, miss, prot, multi;
   logic        wen = 1'b0;
   logic [2:0]  widx = '0;
   logic        wvld = 1'b0;
   logic [19:0] wvpn = '0;
   logic [7:0]  wasid = '0;
   logic [16:0] wppn = '0;
   logic        wrej;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   asid_tlb_xlate i_asid_tlb_xlate (
      .clk(clk), .rst_n(rst_n), .va_i(va), .asid_i(asid),
      .shared_mode_i(shmode), .priv_i(priv), .pa_o(pa), .ok_o(ok),
      .miss_o(miss), .prot_o(prot), .multi_o(multi), .wr_en_i(wen),
      .wr_idx_i(widx), .wr_valid_i(wvld), .wr_vpn_i(wvpn),
      .wr_asid_i(wasid), .wr_ppn_i(wppn), .wr_rej_o(wrej));

   // outcome code {ok,miss,prot,multi}
   task automatic lookup(input string tag, input logic [31:0] a, input logic [7:0] id,
                         input logic sh, input logic pv,
                         input logic [31:0] exp_pa, input logic [3:0] exp_fl);
      @(negedge clk);
      va = a; asid = id; shmode = sh; priv = pv;
      #1;
      total++;
      if (pa !== exp_pa || {ok, miss, prot, multi} !== exp_fl) begin
         bad++;
         $display("FAIL %s va=%h: pa=%h flags=%b expected pa=%h flags=%b",
                  tag, a, pa, {ok, miss, prot, multi}, exp_pa, exp_fl);
      end
   endtask

   task automatic load(input string tag, input logic sh, input logic [2:0] idx,
                       input logic v, input logic [19:0] vp, input logic [7:0] id,
                       input logic [16:0] pp, input logic exp_rej);
      @(negedge clk);
      shmode = sh; wen = 1'b1; widx = idx; wvld = v; wvpn = vp; wasid = id; wppn = pp;
      #1;
      total++;
      if (wrej !== exp_rej) begin
         bad++;
         $display("FAIL %s wr_rej=%b expected %b", tag, wrej, exp_rej);
      end
      @(posedge clk);
      @(negedge clk);
      wen = 1'b0;
   endtask

   localparam logic [3:0] F_OK = 4'b1000, F_MISS = 4'b0100, F_PROT = 4'b0010, F_MULTI = 4'b0001;

   task automatic t_reset;
      lookup("R1 empty user", 32'h0001_2345, 8'd5, 1'b1, 1'b0, 32'h0, F_MISS);
      lookup("R1 empty p3", 32'hC004_0ABC, 8'd5, 1'b1, 1'b1, 32'h0, F_MISS);
   endtask

   task automatic t_fixed_regions;
      lookup("R2 ctrl", 32'hE123_4567, 8'd1, 1'b1, 1'b0, 32'hE123_4567, F_OK);
      lookup("R2 ctrl top", 32'hFFFF_FFFC, 8'd1, 1'b0, 1'b0, 32'hFFFF_FFFC, F_OK);
      lookup("R3 p1", 32'h8123_4567, 8'd1, 1'b1, 1'b1, 32'h0123_4567, F_OK);
      lookup("R3 p2", 32'hB000_0010, 8'd1, 1'b0, 1'b0, 32'h1000_0010, F_OK);
   endtask

   task automatic t_fill_and_hit;
      load("R12 load e0", 1'b1, 3'd0, 1'b1, 20'h00012, 8'd5, 17'h0ABCD, 1'b0);
      load("R12 load e1", 1'b1, 3'd1, 1'b1, 20'hC0040, 8'd5, 17'h00777, 1'b0);
      lookup("R4 user hit", 32'h0001_2345, 8'd5, 1'b1, 1'b0, 32'h0ABC_D345, F_OK);
      lookup("R4 p3 hit", 32'hC004_0ABC, 8'd5, 1'b1, 1'b1, 32'h0077_7ABC, F_OK);
      lookup("R3 p1 same page bits", 32'h8001_2345, 8'd5, 1'b1, 1'b0, 32'h0001_2345, F_OK);
      lookup("R5 no entry", 32'h0005_0000, 8'd5, 1'b1, 1'b0, 32'h0, F_MISS);
   endtask

   task automatic t_id_modes;
      lookup("R6 shared id differs", 32'h0001_2345, 8'd6, 1'b1, 1'b0, 32'h0, F_MISS);
      lookup("R6 shared priv id differs", 32'h0001_2345, 8'd6, 1'b1, 1'b1, 32'h0, F_MISS);
      lookup("R7 excl priv", 32'h0001_2345, 8'd6, 1'b0, 1'b1, 32'h0ABC_D345, F_OK);
      lookup("R8 excl user", 32'h0001_2345, 8'd6, 1'b0, 1'b0, 32'h0, F_PROT);
      lookup("R8 excl user same id", 32'h0001_2345, 8'd5, 1'b0, 1'b0, 32'h0ABC_D345, F_OK);
   endtask

   task automatic t_reject;
      load("R9 clash refused", 1'b0, 3'd2, 1'b1, 20'h00012, 8'd9, 17'h01234, 1'b1);
      lookup("R9 table unchanged", 32'h0001_2345, 8'd9, 1'b0, 1'b1, 32'h0ABC_D345, F_OK);
      load("R9 no clash", 1'b0, 3'd2, 1'b1, 20'h00030, 8'd9, 17'h01234, 1'b0);
      lookup("R12 e2 loaded", 32'h0003_0FFF, 8'd9, 1'b0, 1'b0, 32'h0123_4FFF, F_OK);
   endtask

   task automatic t_multi;
      load("R9 shared never refused", 1'b1, 3'd3, 1'b1, 20'h00012, 8'd5, 17'h01111, 1'b0);
      lookup("R10 two matches", 32'h0001_2345, 8'd5, 1'b1, 1'b0, 32'h0, F_MULTI);
      lookup("R11 other id single", 32'h0001_2345, 8'd7, 1'b1, 1'b0, 32'h0, F_MISS);
   endtask

   task automatic t_overwrite;
      load("R12 invalidate e3", 1'b1, 3'd3, 1'b0, 20'h00012, 8'd5, 17'h01111, 1'b0);
      lookup("R12 single again", 32'h0001_2345, 8'd5, 1'b1, 1'b0, 32'h0ABC_D345, F_OK);
      load("R12 rewrite e1", 1'b1, 3'd1, 1'b1, 20'hC0040, 8'd5, 17'h00888, 1'b0);
      lookup("R12 new page", 32'hC004_0ABC, 8'd5, 1'b1, 1'b0, 32'h0088_8ABC, F_OK);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed_regions();
      t_fill_and_hit();
      t_id_modes();
      t_reject();
      t_multi();
      t_overwrite();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule